// File: doc/BRIEF.md
# Normally-Not-Ready Wait State Generator

This block drives a bus READY line that rests low and rises only when a selected device's ready request has travelled through a short clocked delay line. A strobe that marks the start of each bus cycle empties every delay stage and pulls READY low. From then on, each rising clock edge moves the two request inputs one stage further along their own delay lines. When the far end of either line goes high, READY is set.

Each request input serves a different group of devices and has its own delay depth, fixed by a parameter between 0 and 7 clocks. A group with depth d therefore sees d+1 wait-state clocks after the strobe. If neither request is ever asserted, READY stays low and the bus cycle is held open for as long as that lasts. Once set, READY stays high until the next strobe.

Top module: `nrdy_wait_gen`

## Requirements
- R1: While the active-low reset is asserted, and after it is released while no request has arrived, `ready` is 0. Release of reset empties the delay lines in the same way as a strobe.
- R2: A clock edge that samples `cyc_start` high clears every delay stage and leaves `ready` at 0 after that edge, whatever the request inputs are.
- R3: Take a strobe edge as edge 0. If `req_a` is held at 1 from edge 1 on, `ready` first reads 1 after edge DEPTH_A+1. This holds for depth 0 too.
- R4: Under the same timing, `req_b` held at 1 makes `ready` first read 1 after edge DEPTH_B+1.
- R5: Either request alone is enough to set `ready`. When both are held at 1, `ready` rises after edge min(DEPTH_A, DEPTH_B)+1.
- R6: With both requests at 0 after a strobe, `ready` stays 0 for any number of edges.
- R7: Once `ready` is 1, it stays 1 until an edge samples `cyc_start` high, even after the requests return to 0.
- R8: A request still travelling through a delay line when a new strobe edge comes is discarded and never sets `ready`.
- R9: After the k-th edge since the last strobe or reset release, `ready` is 1 exactly when some edge j with 1 <= j <= k-DEPTH_A sampled `req_a` high, or some edge j with 1 <= j <= k-DEPTH_B sampled `req_b` high.
- R10: DEPTH_A and DEPTH_B may each take any value from 0 to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; every stage moves on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | Bus-cycle start strobe (address latch enable) |
| req_a | input | 1 | Ready request from device group A |
| req_b | input | 1 | Ready request from device group B |
| ready | output | 1 | Registered READY to the processor, high means the cycle may complete |

## Verification
An input that a rising edge samples reaches `ready` after that edge plus the input's depth. So a request first sampled at edge j is due to show on `ready` after edge j+DEPTH. A strobe has its effect after the same edge that samples it. The bench changes inputs only on falling edges and compares `ready` on the next falling edge against a history model of the requests sampled since the last strobe. Two instances with different depths, including 0 and 7, are checked side by side, and the directed latency runs count edges from the strobe to the first high `ready`.

// File: rtl/nrdy_pkg.sv
package nrdy_pkg;

  // Largest delay depth the generator is specified for.
  localparam int unsigned NRDY_MAX_DEPTH = 7;

  // Number of clock edges from a strobe edge until READY is first high when a
  // request at the given depth is held asserted from the first edge on.
  function automatic int unsigned wait_clocks(input int unsigned depth);
    return depth + 1;
  endfunction

  // Shorter of two depths: the path that wins when both requests are held.
  function automatic int unsigned shorter_depth(input int unsigned da,
                                                input int unsigned db);
    return (da < db) ? da : db;
  endfunction

  // True when a depth lies in the supported range.
  function automatic bit depth_ok(input int unsigned depth);
    return depth <= NRDY_MAX_DEPTH;
  endfunction

endpackage

// File: rtl/nrdy_delay_line.sv
// Clearable shift line: the request moves one stage per rising edge; the tap is
// the last stage, or the raw input itself when the depth is zero.
module nrdy_delay_line #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic din,
  output logic tap
);

  generate
    if (DEPTH == 0) begin : g_pass
      assign tap = din;
    end else begin : g_shift
      logic [DEPTH-1:0] stage;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage <= '0;
        end else if (clear) begin
          stage <= '0;
        end else begin
          stage[0] <= din;
          for (int i = 1; i < int'(DEPTH); i++) begin
            stage[i] <= stage[i-1];
          end
        end
      end

      assign tap = stage[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/nrdy_ready_hold.sv
// READY register: cleared by the strobe, set by any tap, then held.
module nrdy_ready_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic set,
  output logic ready
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b0;
    end else if (clear) begin
      ready <= 1'b0;
    end else if (set) begin
      ready <= 1'b1;
    end
  end

endmodule

// File: rtl/nrdy_wait_gen.sv
module nrdy_wait_gen
  import nrdy_pkg::*;
#(
  parameter int unsigned DEPTH_A = 2,
  parameter int unsigned DEPTH_B = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic req_a,
  input  logic req_b,
  output logic ready
);

  localparam bit DEPTHS_VALID = depth_ok(DEPTH_A) && depth_ok(DEPTH_B);

  generate
    if (!DEPTHS_VALID) begin : g_bad_depth
      initial $error("nrdy_wait_gen: depth outside 0..%0d", NRDY_MAX_DEPTH);
    end
  endgenerate

  // Named internal events, brought out for the checker.
  logic chain_clear;
  logic tap_a;
  logic tap_b;
  logic any_tap;

  assign chain_clear = cyc_start;

  nrdy_delay_line #(.DEPTH(DEPTH_A)) u_line_a (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (chain_clear),
    .din   (req_a),
    .tap   (tap_a)
  );

  nrdy_delay_line #(.DEPTH(DEPTH_B)) u_line_b (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (chain_clear),
    .din   (req_b),
    .tap   (tap_b)
  );

  assign any_tap = tap_a | tap_b;

  nrdy_ready_hold u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (chain_clear),
    .set   (any_tap),
    .ready (ready)
  );

endmodule

// File: rtl/nrdy_wait_gen_chk.sv
module nrdy_wait_gen_chk
  import nrdy_pkg::*;
#(
  parameter int unsigned DEPTH_A = 2,
  parameter int unsigned DEPTH_B = 5
) (
  input logic clk,
  input logic rst_n,
  input logic cyc_start,
  input logic tap_a,
  input logic tap_b,
  input logic ready
);

  localparam int unsigned FIRST_OK = wait_clocks(shorter_depth(DEPTH_A, DEPTH_B));

  // Edges since the last strobe or reset release, saturating.
  logic [3:0] since_clr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_clr <= '0;
    else if (cyc_start)      since_clr <= '0;
    else if (since_clr != 4'hF) since_clr <= since_clr + 4'd1;
  end

  // R2
  a_r2_strobe_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !ready);

  // R7
  a_r7_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !cyc_start) |=> ready);

  // R5
  a_r5_tap_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ((tap_a || tap_b) && !cyc_start) |=> ready);

  // R6
  a_r6_rise_needs_tap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(tap_a || tap_b));

  // R3
  a_r3_no_early_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (32'(since_clr) >= FIRST_OK));

endmodule

bind nrdy_wait_gen nrdy_wait_gen_chk #(
  .DEPTH_A (DEPTH_A),
  .DEPTH_B (DEPTH_B)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cyc_start (cyc_start),
  .tap_a     (tap_a),
  .tap_b     (tap_b),
  .ready     (ready)
);

// File: tb/nrdy_wait_gen_bench.sv
module nrdy_wait_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int M_A = 2;
  localparam int M_B = 5;
  localparam int X_A = 0;
  localparam int X_B = 7;
  localparam int HMAX = 255;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_start = 1'b0;
  logic req_a = 1'b0;
  logic req_b = 1'b0;
  logic rdy_m;
  logic rdy_x;

  always #(CLK_PERIOD/2) clk = ~clk;

  nrdy_wait_gen #(.DEPTH_A(M_A), .DEPTH_B(M_B)) u_nrdy_wait_gen (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
    .req_a(req_a), .req_b(req_b), .ready(rdy_m));

  nrdy_wait_gen #(.DEPTH_A(X_A), .DEPTH_B(X_B)) u_nrdy_wait_gen_alt (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
    .req_a(req_a), .req_b(req_b), .ready(rdy_x));

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // Request history since the last clear: entry j is the value sampled at edge j.
  bit hist_a [0:HMAX];
  bit hist_b [0:HMAX];
  int k = 0;

  function automatic bit seen(input int kk, input int d, input bit use_b);
    for (int j = 1; j <= kk - d; j++) begin
      if (use_b ? hist_b[j] : hist_a[j]) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic bit exp_ready(input int da, input int db);
    return seen(k, da, 1'b0) | seen(k, db, 1'b1);
  endfunction

  task automatic check_bit(input string tag, input string what,
                           input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b (k=%0d)", tag, what, act, exp, k);
    end
  endtask

  task automatic check_both(input string tag);
    check_bit(tag, "ready main", rdy_m, exp_ready(M_A, M_B));
    check_bit(tag, "ready alt", rdy_x, exp_ready(X_A, X_B));
  endtask

  task automatic step(input bit s, input bit a, input bit b, input string tag);
    cyc_start = s; req_a = a; req_b = b;
    @(posedge clk);
    if (s) begin
      k = 0;
    end else begin
      if (k < HMAX) k++;
      hist_a[k] = a;
      hist_b[k] = b;
    end
    @(negedge clk);
    check_both(tag);
  endtask

  // Hold the chosen requests from edge 1 and count edges to the first high ready.
  task automatic latency(input bit a, input bit b, input int exp_m,
                         input int exp_x, input string tag);
    int first_m = -1;
    int first_x = -1;
    step(1'b1, 1'b0, 1'b0, "R2");
    check_bit("R2", "ready after strobe", rdy_m, 1'b0);
    for (int n = 1; n <= 12; n++) begin
      step(1'b0, a, b, tag);
      if (rdy_m && first_m < 0) first_m = n;
      if (rdy_x && first_x < 0) first_x = n;
    end
    n_checks++;
    if (first_m != exp_m) begin
      n_fail++;
      $display("FAIL %s latency main: actual %0d expected %0d", tag, first_m, exp_m);
    end
    n_checks++;
    if (first_x != exp_x) begin
      n_fail++;
      $display("FAIL %s latency alt: actual %0d expected %0d", tag, first_x, exp_x);
    end
  endtask

  function automatic int mn(input int p, input int q);
    return (p < q) ? p : q;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (3) @(negedge clk);
    check_bit("R1", "ready main in reset", rdy_m, 1'b0);
    check_bit("R1", "ready alt in reset", rdy_x, 1'b0);
    rst_n = 1'b1;
    k = 0;
    repeat (3) step(1'b0, 1'b0, 1'b0, "R1");

    // R3 / R4 / R5 / R10: latency per depth
    latency(1'b1, 1'b0, M_A + 1, X_A + 1, "R3");
    latency(1'b0, 1'b1, M_B + 1, X_B + 1, "R4");
    latency(1'b1, 1'b1, mn(M_A, M_B) + 1, mn(X_A, X_B) + 1, "R5");
    latency(1'b0, 1'b1, M_B + 1, X_B + 1, "R10");

    // R2: strobe with both requests high still clears
    step(1'b1, 1'b1, 1'b1, "R2");
    check_bit("R2", "ready main strobe with requests", rdy_m, 1'b0);

    // R6: no request, ready stays low
    step(1'b1, 1'b0, 1'b0, "R6");
    repeat (40) step(1'b0, 1'b0, 1'b0, "R6");
    check_bit("R6", "ready main after 40 idle edges", rdy_m, 1'b0);

    // R7: single pulse, then requests drop; ready holds
    step(1'b1, 1'b0, 1'b0, "R7");
    step(1'b0, 1'b1, 1'b0, "R7");
    repeat (12) step(1'b0, 1'b0, 1'b0, "R7");
    check_bit("R7", "ready main held", rdy_m, 1'b1);
    check_bit("R7", "ready alt held", rdy_x, 1'b1);

    // R8: pulse on group B cut off by a new strobe
    step(1'b1, 1'b0, 1'b0, "R8");
    step(1'b0, 1'b0, 1'b1, "R8");
    repeat (2) step(1'b0, 1'b0, 1'b0, "R8");
    step(1'b1, 1'b0, 1'b0, "R8");
    repeat (10) step(1'b0, 1'b0, 1'b0, "R8");
    check_bit("R8", "ready main after discarded request", rdy_m, 1'b0);
    check_bit("R8", "ready alt after discarded request", rdy_x, 1'b0);

    // R9: random interleavings
    for (int i = 0; i < 600; i++) begin
      bit s;
      bit a;
      bit b;
      s = ($urandom % 12) == 0;
      a = ($urandom % 6) == 0;
      b = ($urandom % 5) == 0;
      step(s, a, b, "R9");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule